// File: doc/BRIEF.md
# Hitless Slotted/Packet Egress Transmitter

This block feeds one optical line port from a byte-wide payload buffer. It has two transport modes. In slotted mode it builds repeating frames from a programmable number of slots. An allocated slot sends a programmable number of preamble bytes and then a programmable number of payload bytes, aggregating packets without regard to their edges. An unallocated slot keeps the same length on the wire but sends nothing. In packet mode it forwards the buffer's Ethernet frames unchanged, one byte per handshake.

Software writes a complete configuration in one cycle: mode, slice length, preamble length, slot count and slot allocation bitmap. The write goes into a shadow copy. The active set takes the shadow copy only at a safe point. In slotted mode that point is the end of a frame, or the end of the current slot when the new mode is packet mode. In packet mode it is the gap between two packets. Because of this a change of parameters or of transport loses no byte and cuts no packet. Both edges use valid/ready handshakes. The line side also sees an end-of-slot marker and a frame-start strobe.

Top module: `slice_tx`

## Requirements
- R1: After reset the block is in packet mode with no staged update: with `in_valid` low, `out_valid` and `frame_start` are low and `in_ready` equals `out_ready`.
- R2: In packet mode with no update pending at a packet gap, `out_valid`/`out_data`/`out_last` follow `in_valid`/`in_data`/`in_last` in the same cycle, and `in_ready` equals `out_ready`.
- R3: In slotted mode an allocated slot lasts `ovh_len + slice_len` accepted byte times. The first `ovh_len` bytes are the preamble value 0x55 and consume no payload. `out_last` is high on the final byte of the slot only.
- R4: In the payload part of an allocated slot, a cycle with `in_valid` low still sends a byte, with the fill value 0x00, so slot timing is kept.
- R5: An unallocated slot lasts `ovh_len + slice_len` cycles with `out_valid` and `in_ready` held low. Bit k of `cfg_alloc` (bit 0 = first slot) set to 1 marks slot k as allocated.
- R6: `frame_start` is a one-cycle pulse in the first cycle of slot 0 of every slotted frame, and it never occurs in packet mode.
- R7: A configuration write has no effect on the frame in progress. Slotted-to-slotted changes take effect from the next frame.
- R8: A write selecting packet mode, made during a slotted slot, lets that slot finish in full. Packet forwarding starts in the following cycle.
- R9: A write selecting slotted mode, made while a packet is in progress, lets that packet finish through its `in_last` byte. The block then spends one cycle with `out_valid` and `in_ready` low, and the first frame starts in the next cycle.
- R10: With `ovh_len` = 0 an allocated slot begins with payload in its first byte.
- R11: No byte is lost or duplicated. A byte is accepted only in a cycle where it is presented on `out_data` with `out_valid` and `out_ready` high, and payload appears in input order.
- R12: While `out_ready` is low in an allocated slot, the slot position does not advance and no payload is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Stage the configuration fields below |
| cfg_pkt_mode | input | 1 | 1 = packet mode, 0 = slotted mode |
| cfg_slice_len | input | 16 | Payload bytes per allocated slot |
| cfg_ovh_len | input | 16 | Preamble bytes per slot (0 = none) |
| cfg_slots | input | 7 | Slots per frame |
| cfg_alloc | input | 100 | Slot allocation bitmap, bit k = slot k |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Last byte of a packet |
| in_ready | output | 1 | Payload byte accepted this cycle |
| out_valid | output | 1 | Line byte valid |
| out_data | output | 8 | Line byte |
| out_last | output | 1 | End of packet (packet mode) or end of slot (slotted mode) |
| out_ready | input | 1 | Line side takes the byte |
| frame_start | output | 1 | Pulse in the first cycle of a slotted frame |

## Verification
The bound checker watches, on every cycle, the handshake rules that keep the stream lossless. It checks that payload is taken only when the line takes it, and that it is forwarded unchanged. It also checks that the frame strobe is a single-cycle pulse that never appears in packet mode, that the slot position freezes under back-pressure, and that packet mode is never left while a packet is open. Slot layout, preamble and fill bytes, the deferral of a staged write to a frame boundary, and the exact cycle at which each mode switch lands depend on the programmed values. Only the bench's directed scenarios can show these.

// File: rtl/slice_tx_pkg.sv
package slice_tx_pkg;
    localparam int MAX_SLOTS = 100;
    localparam int LEN_W     = 16;
    localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);
    localparam int POS_W     = LEN_W + 1;
    localparam logic [7:0] PRE_BYTE  = 8'h55;
    localparam logic [7:0] FILL_BYTE = 8'h00;

    typedef struct packed {
        logic                 pkt;
        logic [LEN_W-1:0]     slice_len;
        logic [LEN_W-1:0]     ovh_len;
        logic [SLOT_W-1:0]    slots;
        logic [MAX_SLOTS-1:0] alloc;
    } cfg_t;
endpackage

// File: rtl/slice_tx_cfg.sv
module slice_tx_cfg
    import slice_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cfg_t wr_cfg,
    input  logic apply,
    output cfg_t act,
    output logic next_pkt,
    output logic pending
);
    typedef struct packed {
        cfg_t act;
        cfg_t shd;
        logic pend;
    } st_t;

    localparam cfg_t RST_CFG = '{pkt: 1'b1, slice_len: LEN_W'(1), ovh_len: '0,
                                 slots: SLOT_W'(4), alloc: '0};

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply) begin
            st_d.act  = st_q.shd;
            st_d.pend = 1'b0;
        end
        if (we) begin
            st_d.shd  = wr_cfg;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{act: RST_CFG, shd: RST_CFG, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign act      = st_q.act;
    assign next_pkt = st_q.shd.pkt;
    assign pending  = st_q.pend;
endmodule

// File: rtl/slice_tx_seq.sv
module slice_tx_seq
    import slice_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_mode,
    input  logic [LEN_W-1:0]  ovh_len,
    input  logic [LEN_W-1:0]  slice_len,
    input  logic [SLOT_W-1:0] slots,
    input  logic              pending,
    input  logic              next_pkt,
    input  logic              step,
    input  logic              xfer,
    input  logic              xfer_last,
    output logic [SLOT_W-1:0] slot,
    output logic [POS_W-1:0]  pos,
    output logic              slot_end,
    output logic              hold,
    output logic              apply,
    output logic              frame_start,
    output logic              pkt_open
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [POS_W-1:0]  pos;
        logic              fs;
        logic              open;
    } st_t;

    st_t st_d, st_q;
    logic [POS_W-1:0] slot_len;
    logic             last_slot;

    always_comb begin
        slot_len  = POS_W'(ovh_len) + POS_W'(slice_len);
        slot_end  = (st_q.pos == slot_len - POS_W'(1));
        last_slot = (st_q.slot == slots - SLOT_W'(1));
        hold      = pkt_mode && pending && !st_q.open;
        apply     = 1'b0;
        st_d      = st_q;
        st_d.fs   = 1'b0;
        if (pkt_mode) begin
            if (xfer) st_d.open = !xfer_last;
            if (hold) begin
                apply     = 1'b1;
                st_d.slot = '0;
                st_d.pos  = '0;
                st_d.fs   = !next_pkt;
            end
        end else if (step) begin
            if (slot_end) begin
                st_d.pos = '0;
                if (pending && next_pkt) begin
                    apply     = 1'b1;
                    st_d.slot = '0;
                    st_d.open = 1'b0;
                end else if (last_slot) begin
                    st_d.slot = '0;
                    st_d.fs   = 1'b1;
                    apply     = pending;
                end else begin
                    st_d.slot = st_q.slot + SLOT_W'(1);
                end
            end else begin
                st_d.pos = st_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot        = st_q.slot;
    assign pos         = st_q.pos;
    assign frame_start = st_q.fs;
    assign pkt_open    = st_q.open;
endmodule

// File: rtl/slice_tx.sv
module slice_tx
    import slice_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_pkt_mode,
    input  logic [LEN_W-1:0]     cfg_slice_len,
    input  logic [LEN_W-1:0]     cfg_ovh_len,
    input  logic [SLOT_W-1:0]    cfg_slots,
    input  logic [MAX_SLOTS-1:0] cfg_alloc,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_last,
    input  logic                 out_ready,
    output logic                 frame_start
);
    cfg_t              wr_cfg, act;
    logic              next_pkt, pending, apply, hold, step, xfer;
    logic              slot_end, pkt_open, alloc_now, in_pre;
    logic [SLOT_W-1:0] slot;
    logic [POS_W-1:0]  pos;

    assign wr_cfg = '{pkt: cfg_pkt_mode, slice_len: cfg_slice_len, ovh_len: cfg_ovh_len,
                      slots: cfg_slots, alloc: cfg_alloc};

    slice_tx_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_cfg(wr_cfg), .apply(apply),
        .act(act), .next_pkt(next_pkt), .pending(pending)
    );

    slice_tx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .pkt_mode(act.pkt), .ovh_len(act.ovh_len),
        .slice_len(act.slice_len), .slots(act.slots), .pending(pending),
        .next_pkt(next_pkt), .step(step), .xfer(xfer), .xfer_last(in_last),
        .slot(slot), .pos(pos), .slot_end(slot_end), .hold(hold), .apply(apply),
        .frame_start(frame_start), .pkt_open(pkt_open)
    );

    always_comb begin
        alloc_now = !act.pkt && act.alloc[slot];
        in_pre    = pos < POS_W'(act.ovh_len);
        if (act.pkt) begin
            out_valid = in_valid && !hold;
            out_data  = in_data;
            out_last  = in_last;
            in_ready  = out_ready && !hold;
            step      = 1'b0;
        end else begin
            out_valid = alloc_now;
            out_data  = in_pre ? PRE_BYTE : (in_valid ? in_data : FILL_BYTE);
            out_last  = alloc_now && slot_end;
            in_ready  = alloc_now && !in_pre && out_ready;
            step      = alloc_now ? out_ready : 1'b1;
        end
        xfer = act.pkt && in_valid && in_ready;
    end
endmodule

// File: rtl/slice_tx_chk.sv
module slice_tx_chk
    import slice_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             frame_start,
    input logic             pkt_mode,
    input logic             pkt_open,
    input logic [POS_W-1:0] pos,
    input logic             alloc_now
);
    AST_TAKE_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);  // R11
    AST_TAKE_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_data == in_data));  // R11
    AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);  // R6
    AST_FS_SLOTTED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !pkt_mode);  // R6
    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_mode && alloc_now && !out_ready) |=> $stable(pos));  // R12
    AST_PKT_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_mode && pkt_open) |=> pkt_mode);  // R9
endmodule

bind slice_tx slice_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_start(frame_start), .pkt_mode(act.pkt),
    .pkt_open(pkt_open), .pos(pos), .alloc_now(alloc_now)
);

// File: tb/tb_slice_tx.sv
module tb_slice_tx;
    import slice_tx_pkg::*;
    localparam time CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_pkt_mode = 1'b0;
    logic [LEN_W-1:0] cfg_slice_len = '0, cfg_ovh_len = '0;
    logic [SLOT_W-1:0] cfg_slots = '0;
    logic [MAX_SLOTS-1:0] cfg_alloc = '0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = '0;
    logic in_ready, out_valid, out_last, frame_start;
    logic [7:0] out_data;
    logic [7:0] src_b = 8'h00;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    slice_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pkt_mode(cfg_pkt_mode),
        .cfg_slice_len(cfg_slice_len), .cfg_ovh_len(cfg_ovh_len), .cfg_slots(cfg_slots),
        .cfg_alloc(cfg_alloc), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic adv();
        if (in_valid && in_ready) src_b = src_b + 8'd1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cfg(input bit pkt, input int slc, input int ovh, input int n,
                            input logic [MAX_SLOTS-1:0] map);
        cfg_pkt_mode  = pkt;
        cfg_slice_len = LEN_W'(slc);
        cfg_ovh_len   = LEN_W'(ovh);
        cfg_slots     = SLOT_W'(n);
        cfg_alloc     = map;
    endtask

    task automatic slot_alloc(input int ovh, input int slc, input bit fill, input bit fs_first,
                              input int we_at, input int stall_at);
        for (int i = 0; i < ovh + slc; i++) begin
            if (i == stall_at) begin
                out_ready = 1'b0; in_valid = 1'b1; in_data = src_b;
                for (int k = 0; k < 2; k++) begin
                    #1;
                    chk(out_valid == 1'b1, "R12 valid under stall", int'(out_valid), 1);
                    chk(in_ready == 1'b0, "R12 no take under stall", int'(in_ready), 0);
                    chk(out_data == src_b, "R12 byte held", int'(out_data), int'(src_b));
                    adv();
                end
                out_ready = 1'b1;
            end
            in_valid = !fill; in_data = src_b; in_last = 1'b0;
            if (i == we_at) cfg_we = 1'b1;
            #1;
            chk(out_valid == 1'b1, "R3 allocated byte valid", int'(out_valid), 1);
            if (i < ovh) begin
                chk(out_data == PRE_BYTE, "R3 preamble byte", int'(out_data), int'(PRE_BYTE));
                chk(in_ready == 1'b0, "R3 preamble takes no payload", int'(in_ready), 0);
            end else if (fill) begin
                chk(out_data == FILL_BYTE, "R4 fill byte", int'(out_data), int'(FILL_BYTE));
            end else begin
                chk(out_data == src_b, "R11 payload order", int'(out_data), int'(src_b));
                chk(in_ready == 1'b1, "R11 payload taken", int'(in_ready), 1);
            end
            chk(out_last == (i == ovh + slc - 1), "R3 slot end marker", int'(out_last),
                int'(i == ovh + slc - 1));
            chk(frame_start == (fs_first && i == 0), "R6 frame strobe", int'(frame_start),
                int'(fs_first && i == 0));
            adv();
        end
    endtask

    task automatic slot_idle(input int len, input bit fs_first);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1; in_data = src_b;
            #1;
            chk(out_valid == 1'b0, "R5 idle slot silent", int'(out_valid), 0);
            chk(in_ready == 1'b0, "R5 idle slot takes nothing", int'(in_ready), 0);
            chk(frame_start == (fs_first && i == 0), "R6 frame strobe", int'(frame_start),
                int'(fs_first && i == 0));
            adv();
        end
    endtask

    task automatic test_reset();
        in_valid = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
        chk(in_ready == 1'b1, "R1 in_ready follows out_ready", int'(in_ready), 1);
        adv();
    endtask

    task automatic test_packet();
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'(8'hA0 + i); in_last = (i == 2);
            #1;
            chk(out_valid == 1'b1, "R2 valid passthrough", int'(out_valid), 1);
            chk(out_data == in_data, "R2 data passthrough", int'(out_data), int'(in_data));
            chk(out_last == in_last, "R2 last passthrough", int'(out_last), int'(in_last));
            chk(in_ready == 1'b1, "R2 ready passthrough", int'(in_ready), 1);
            adv();
        end
        out_ready = 1'b0; in_valid = 1'b1; in_last = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R2 back-pressure", int'(in_ready), 0);
        out_ready = 1'b1; in_valid = 1'b0;
        adv();
    endtask

    task automatic test_to_slotted();
        load_cfg(1'b0, 4, 2, 4, 100'b0101);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'(8'hB0 + i); in_last = (i == 2);
            if (i == 0) cfg_we = 1'b1;
            #1;
            chk(out_valid == 1'b1 && out_data == in_data, "R9 packet finishes",
                int'(out_data), int'(in_data));
            adv();
        end
        in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R9 switch gap valid", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R9 switch gap ready", int'(in_ready), 0);
        adv();
        src_b = 8'h10;
    endtask

    task automatic test_frame_layout();
        slot_alloc(2, 4, 1'b0, 1'b1, -1, -1);
        slot_idle(6, 1'b0);
        slot_alloc(2, 4, 1'b0, 1'b0, -1, -1);
        slot_idle(6, 1'b0);
    endtask

    task automatic test_staged_and_fill();
        load_cfg(1'b0, 3, 0, 4, 100'b0011);
        slot_alloc(2, 4, 1'b1, 1'b1, 0, -1);
        slot_idle(6, 1'b0);
        slot_alloc(2, 4, 1'b0, 1'b0, -1, -1);  // R7 old layout still active
        slot_idle(6, 1'b0);
    endtask

    task automatic test_no_preamble_and_to_packet();
        slot_alloc(0, 3, 1'b0, 1'b1, -1, 1);   // R10 and R12
        load_cfg(1'b1, 3, 0, 4, 100'b0011);
        slot_alloc(0, 3, 1'b0, 1'b0, 0, -1);   // R8 slot completes after write
        in_valid = 1'b1; in_data = 8'hC5; in_last = 1'b1;
        #1;
        chk(out_valid == 1'b1 && out_data == 8'hC5, "R8 packet forwarding begins",
            int'(out_data), 'hC5);
        chk(frame_start == 1'b0, "R8 no frame strobe", int'(frame_start), 0);
        chk(out_last == 1'b1, "R8 packet last", int'(out_last), 1);
        adv();
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_packet();
        test_to_slotted();
        test_frame_layout();
        test_staged_and_fill();
        test_no_preamble_and_to_packet();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule